// File: doc/BRIEF.md
# Dual-Clock Transmit Byte Buffer with Frame-Start Retention

This block sits between a byte producer running on the system clock and a transmit engine running on its own line clock. The two clocks have no fixed relation. The producer pushes one byte per accepted strobe and flags the final byte of each frame. The transmit engine pulls bytes and sees that end flag in the same entry as the data.

While the engine is still contending for the medium, it may need to restart the frame. For that reason the buffer keeps the head of the current frame, up to a retention window of `HOLD_BYTES` bytes, and does not release it until the engine signals that the medium has been acquired. Until then a rewind pulse returns the read position to the first byte of the frame. The engine reads at most the retention window before reads stall. Once the medium is acquired, bytes are released as they are read. Reading the end-of-frame byte closes the frame, and the next byte becomes the new frame start.

The engine also gets a start indication, which is high once at least `START_BYTES` unread bytes are visible on its side. Pointers cross between the clock domains in Gray code through two-flop synchronizers. The released pointer moves by at most one position per read clock, so the single-bit-change rule always holds.

Top module: `txbuf_dualclk`

## Requirements
- R1: After both resets, `rd_valid` and `rd_start_ok` are 0 and `wr_full` is 0.
- R2: Bytes leave in the order written. `rd_last` is 1 exactly for a byte written with `wr_last`=1. A byte is consumed on a read-clock edge where `rd_en` and `rd_valid` are both 1, and `rd_valid` is 0 when no unread byte is visible.
- R3: `rd_start_ok` is 1 when at least `START_BYTES` (8) unread bytes are visible on the read side, and 0 when fewer are visible.
- R4: Until the medium is acquired, the reader can consume at most `HOLD_BYTES` (64) bytes past the frame start. After that, `rd_valid` stays 0 even though more bytes are stored.
- R5: A `rewind` pulse before acquisition makes the next byte read the first byte of the current frame.
- R6: A `rewind` pulse after `medium_acq` and before the frame's end byte is read has no effect, and reading continues with the next byte.
- R7: Unreleased bytes are never overwritten. With nothing released, the writer can store exactly 2^`ADDR_W` (128) bytes past the frame start, and `wr_full` is then 1.
- R8: After `medium_acq`, bytes that have been read are released and the writer can continue. Reading the end-of-frame byte clears the acquisition, and the following byte becomes the new frame start.
- R9: Behaviour R2 to R5 holds when the read clock is ten times slower than in the nominal mode (a 25 MHz versus 2.5 MHz line rate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer (system) clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write strobe; accepted when `wr_full` is 0 |
| wr_data | input | 8 | Byte to store |
| wr_last | input | 1 | Marks the byte as the last of its frame |
| wr_full | output | 1 | No free entry; further strobes are ignored |
| rclk | input | 1 | Transmit line clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Consume the presented byte |
| rewind | input | 1 | Return to the frame start (before acquisition only) |
| medium_acq | input | 1 | Medium acquired; release read bytes of the frame |
| rd_data | output | 8 | Presented byte |
| rd_last | output | 1 | Presented byte ends its frame |
| rd_valid | output | 1 | A byte is presented and may be read |
| rd_start_ok | output | 1 | At least `START_BYTES` unread bytes visible |

## Verification
The reference model keeps every written byte in a queue, together with a read index and a frame-start index. Each byte read is compared against the model, so rewinds, ignored rewinds and frame boundaries all show up as data or end-flag mismatches.

The stimulus is chosen to separate the cases:
- A short frame is filled one byte at a time across the 8-byte threshold, which separates 7 stored bytes from 8.
- A 100-byte frame read without acquisition separates a stall at 64 bytes from a stall at 63 or 65.
- A 200-byte frame written against an idle reader shows whether the full point falls at exactly 128 and whether the retained head survives the writer pressing on it.
- A final frame at a ten-times slower read clock shows that the synchronizer path does not depend on the clock ratio.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

    localparam int unsigned TXB_DATA_W = 8;

    // One stored entry: the byte plus its end-of-frame flag.
    typedef struct packed {
        logic                  last;
        logic [TXB_DATA_W-1:0] data;
    } txbuf_entry_t;

endpackage

// File: rtl/txbuf_sync.sv
module txbuf_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/txbuf_store.sv
module txbuf_store
    import txbuf_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  txbuf_entry_t      wentry,
    input  logic [ADDR_W-1:0] raddr,
    output txbuf_entry_t      rentry
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    txbuf_entry_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wentry;
    end

    // Show-ahead read: the entry at the read address is always presented.
    assign rentry = mem[raddr];
endmodule

// File: rtl/txbuf_wr_ctrl.sv
module txbuf_wr_ctrl #(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              wclk,
    input  logic              wrst,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   free_gray_s,
    output logic              wr_full,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   wr_gray
);
    localparam logic [ADDR_W:0] DEPTH_P = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W:0] ONE_P   = {{ADDR_W{1'b0}}, 1'b1};

    function automatic logic [ADDR_W:0] to_gray(input logic [ADDR_W:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [ADDR_W:0] from_gray(input logic [ADDR_W:0] g);
        logic [ADDR_W:0] b;
        b[ADDR_W] = g[ADDR_W];
        for (int i = ADDR_W - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [ADDR_W:0] wr_bin;
    logic [ADDR_W:0] free_bin;
    logic [ADDR_W:0] used;

    assign free_bin = from_gray(free_gray_s);
    assign used     = wr_bin - free_bin;
    assign wr_full  = (used == DEPTH_P);
    assign wr_fire  = wr_en && !wr_full;
    assign wr_addr  = wr_bin[ADDR_W-1:0];

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else if (wr_fire) begin
            wr_bin  <= wr_bin + ONE_P;
            wr_gray <= to_gray(wr_bin + ONE_P);
        end
    end

    // R7: never more stored-but-unreleased entries than the array holds
    a_r7_no_overrun: assert property (@(posedge wclk) disable iff (wrst)
        used <= DEPTH_P);

    // R7: a strobe while full leaves the write pointer untouched
    a_r7_full_blocks: assert property (@(posedge wclk) disable iff (wrst)
        (wr_en && wr_full) |=> (wr_gray == $past(wr_gray)));
endmodule

// File: rtl/txbuf_rd_ctrl.sv
module txbuf_rd_ctrl #(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned HOLD_BYTES  = 64,
    parameter int unsigned START_BYTES = 8
) (
    input  logic              rclk,
    input  logic              rrst,
    input  logic              rd_en,
    input  logic              rewind,
    input  logic              medium_acq,
    input  logic              last_in,
    input  logic [ADDR_W:0]   wr_gray_s,
    output logic              rd_valid,
    output logic              rd_start_ok,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   free_gray
);
    localparam logic [ADDR_W:0] DEPTH_P = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W:0] ONE_P   = {{ADDR_W{1'b0}}, 1'b1};
    localparam logic [ADDR_W:0] HOLD_P  = (ADDR_W+1)'(HOLD_BYTES);
    localparam logic [ADDR_W:0] START_P = (ADDR_W+1)'(START_BYTES);

    function automatic logic [ADDR_W:0] to_gray(input logic [ADDR_W:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [ADDR_W:0] from_gray(input logic [ADDR_W:0] g);
        logic [ADDR_W:0] b;
        b[ADDR_W] = g[ADDR_W];
        for (int i = ADDR_W - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [ADDR_W:0] rd_bin, frm_bin, free_bin, wr_bin_s;
    logic [ADDR_W:0] avail, held, free_target;
    logic            acquired, hold_block, do_rewind, rd_fire;

    assign wr_bin_s    = from_gray(wr_gray_s);
    assign avail       = wr_bin_s - rd_bin;
    assign held        = rd_bin - frm_bin;
    assign hold_block  = !acquired && (held == HOLD_P);
    assign rd_valid    = (avail != '0) && !hold_block;
    assign rd_start_ok = (avail >= START_P);
    assign do_rewind   = rewind && !acquired;
    assign rd_fire     = rd_en && rd_valid && !do_rewind;
    assign rd_addr     = rd_bin[ADDR_W-1:0];
    assign free_target = acquired ? rd_bin : frm_bin;

    // Read position, frame start and acquisition state.
    always_ff @(posedge rclk) begin
        if (rrst) begin
            rd_bin   <= '0;
            frm_bin  <= '0;
            acquired <= 1'b0;
        end else begin
            if (do_rewind) begin
                rd_bin <= frm_bin;
            end else if (rd_fire) begin
                rd_bin <= rd_bin + ONE_P;
                if (last_in) frm_bin <= rd_bin + ONE_P;
            end
            if (rd_fire && last_in) acquired <= 1'b0;
            else if (medium_acq)    acquired <= 1'b1;
        end
    end

    // Released pointer walks one step per clock so its Gray image changes one bit.
    always_ff @(posedge rclk) begin
        if (rrst) begin
            free_bin  <= '0;
            free_gray <= '0;
        end else if (free_bin != free_target) begin
            free_bin  <= free_bin + ONE_P;
            free_gray <= to_gray(free_bin + ONE_P);
        end
    end

    // R4: before acquisition the reader stays inside the retention window
    a_r4_hold_window: assert property (@(posedge rclk) disable iff (rrst)
        !acquired |-> (held <= HOLD_P));

    // R5: a rewind before acquisition lands on the frame start
    a_r5_rewind_to_start: assert property (@(posedge rclk) disable iff (rrst)
        (rewind && !acquired) |=> (rd_bin == $past(frm_bin)));

    // R6: a rewind after acquisition with no read leaves the position alone
    a_r6_rewind_ignored: assert property (@(posedge rclk) disable iff (rrst)
        (rewind && acquired && !rd_en) |=> $stable(rd_bin));

    // R2: the reader never passes the writer
    a_r2_not_past_writer: assert property (@(posedge rclk) disable iff (rrst)
        avail <= DEPTH_P);

    // R8: the released pointer never runs ahead of the read position
    a_r8_free_behind_read: assert property (@(posedge rclk) disable iff (rrst)
        (rd_bin - free_bin) <= DEPTH_P);

    // R7: released pointer image changes at most one bit per clock
    a_r7_free_one_bit: assert property (@(posedge rclk) disable iff (rrst)
        1'b1 |=> ($countones(free_gray ^ $past(free_gray)) <= 1));
endmodule

// File: rtl/txbuf_dualclk.sv
module txbuf_dualclk
    import txbuf_pkg::*;
#(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned HOLD_BYTES  = 64,
    parameter int unsigned START_BYTES = 8
) (
    input  logic                  wclk,
    input  logic                  wrst,
    input  logic                  wr_en,
    input  logic [TXB_DATA_W-1:0] wr_data,
    input  logic                  wr_last,
    output logic                  wr_full,
    input  logic                  rclk,
    input  logic                  rrst,
    input  logic                  rd_en,
    input  logic                  rewind,
    input  logic                  medium_acq,
    output logic [TXB_DATA_W-1:0] rd_data,
    output logic                  rd_last,
    output logic                  rd_valid,
    output logic                  rd_start_ok
);
    localparam int unsigned PW = ADDR_W + 1;

    logic [PW-1:0]     wr_gray, wr_gray_s, free_gray, free_gray_s;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic              wr_fire;
    txbuf_entry_t      wentry, rentry;

    assign wentry.data = wr_data;
    assign wentry.last = wr_last;
    assign rd_data     = rentry.data;
    assign rd_last     = rentry.last;

    txbuf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .free_gray_s(free_gray_s),
        .wr_full(wr_full), .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_gray(wr_gray)
    );

    txbuf_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst(rrst), .d(wr_gray), .q(wr_gray_s)
    );

    txbuf_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst(wrst), .d(free_gray), .q(free_gray_s)
    );

    txbuf_store #(.ADDR_W(ADDR_W)) u_store (
        .wclk(wclk), .we(wr_fire), .waddr(wr_addr), .wentry(wentry),
        .raddr(rd_addr), .rentry(rentry)
    );

    txbuf_rd_ctrl #(
        .ADDR_W(ADDR_W), .HOLD_BYTES(HOLD_BYTES), .START_BYTES(START_BYTES)
    ) u_rd (
        .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .rewind(rewind),
        .medium_acq(medium_acq), .last_in(rentry.last), .wr_gray_s(wr_gray_s),
        .rd_valid(rd_valid), .rd_start_ok(rd_start_ok), .rd_addr(rd_addr),
        .free_gray(free_gray)
    );
endmodule

// File: tb/txbuf_dualclk_tb.sv
`timescale 1ns/1ps
module txbuf_dualclk_tb;
    logic       wclk = 0, rclk = 0, wrst = 1, rrst = 1;
    logic       wr_en = 0, wr_last = 0, rd_en = 0, rewind = 0, medium_acq = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       wr_full, rd_last, rd_valid, rd_start_ok;

    int         rhalf = 20;
    int         checks = 0, fails = 0, cyc = 0;
    bit         done = 0, acq = 0;
    logic [8:0] stream [$];
    int         rdi = 0, frm = 0;

    txbuf_dualclk u_dut (
        .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
        .wr_full(wr_full), .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .rewind(rewind),
        .medium_acq(medium_acq), .rd_data(rd_data), .rd_last(rd_last),
        .rd_valid(rd_valid), .rd_start_ok(rd_start_ok)
    );

    always #5 wclk = ~wclk;
    always begin #(rhalf); rclk = ~rclk; end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] d, input bit last);
        @(negedge wclk);
        while (wr_full) @(negedge wclk);
        stream.push_back({last, d});
        wr_en = 1; wr_data = d; wr_last = last;
        @(negedge wclk);
        wr_en = 0; wr_last = 0;
    endtask

    task automatic read_one(string req);
        @(negedge rclk);
        while (!rd_valid) @(negedge rclk);
        chk(req, "data", int'(rd_data), int'(stream[rdi][7:0]));
        chk(req, "last", int'(rd_last), int'(stream[rdi][8]));
        rd_en = 1;
        @(negedge rclk);
        rd_en = 0;
        if (stream[rdi][8]) begin acq = 0; frm = rdi + 1; end
        rdi++;
    endtask

    task automatic pulse_rewind();
        @(negedge rclk); rewind = 1;
        @(negedge rclk); rewind = 0;
        if (!acq) rdi = frm;
    endtask

    task automatic pulse_acq();
        @(negedge rclk); medium_acq = 1;
        @(negedge rclk); medium_acq = 0;
        acq = 1;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge rclk);
        repeat (4) @(negedge wclk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge wclk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
            summary();
            $finish;
        end
    end

    initial begin
        int acc;
        repeat (4) @(posedge rclk);
        @(negedge wclk) wrst = 0;
        @(negedge rclk) rrst = 0;
        settle(4);
        chk("R1", "rd_valid", int'(rd_valid), 0);
        chk("R1", "rd_start_ok", int'(rd_start_ok), 0);
        chk("R1", "wr_full", int'(wr_full), 0);

        // Frame A, 20 bytes: threshold, rewind, acquisition
        for (int i = 0; i < 5; i++) write_byte(8'(8'h10 + i), 0);
        settle(6);
        chk("R3", "start_ok at 5", int'(rd_start_ok), 0);
        chk("R2", "valid at 5", int'(rd_valid), 1);
        for (int i = 5; i < 7; i++) write_byte(8'(8'h10 + i), 0);
        settle(6);
        chk("R3", "start_ok at 7", int'(rd_start_ok), 0);
        write_byte(8'h17, 0);
        settle(6);
        chk("R3", "start_ok at 8", int'(rd_start_ok), 1);
        for (int i = 8; i < 20; i++) write_byte(8'(8'h10 + i), i == 19);
        for (int i = 0; i < 10; i++) read_one("R2");
        pulse_rewind();
        for (int i = 0; i < 5; i++) read_one("R5");
        pulse_acq();
        pulse_rewind();
        read_one("R6");
        while (rdi < 20) read_one("R2");
        settle(8);
        chk("R2", "valid after frame", int'(rd_valid), 0);

        // Frame B, 100 bytes: retention window
        settle(200);
        for (int i = 0; i < 100; i++) write_byte(8'(8'h40 + 3 * i), i == 99);
        settle(6);
        for (int i = 0; i < 64; i++) read_one("R4");
        settle(10);
        chk("R4", "valid after 64", int'(rd_valid), 0);
        pulse_rewind();
        for (int i = 0; i < 3; i++) read_one("R5");
        pulse_acq();
        while (rdi < 120) read_one("R8");

        // Frame C, 200 bytes: full point and head protection
        settle(200);
        acc = 0;
        while (acc < 200) begin
            @(negedge wclk);
            wr_en = 0; wr_last = 0;
            if (wr_full) break;
            stream.push_back({1'b0, 8'(8'h80 + 5 * acc)});
            wr_en = 1; wr_data = 8'(8'h80 + 5 * acc); wr_last = 0;
            acc++;
        end
        @(negedge wclk) wr_en = 0;
        chk("R7", "accepted before full", acc, 128);
        settle(10);
        chk("R7", "wr_full held", int'(wr_full), 1);
        chk("R3", "start_ok with full", int'(rd_start_ok), 1);
        fork
            begin
                for (int i = 128; i < 200; i++) write_byte(8'(8'h80 + 5 * i), i == 199);
            end
            begin
                for (int i = 0; i < 64; i++) read_one("R7");
                pulse_acq();
                for (int i = 64; i < 200; i++) read_one("R8");
            end
        join
        settle(200);
        chk("R8", "wr_full released", int'(wr_full), 0);
        chk("R8", "valid after frame", int'(rd_valid), 0);

        // Frame D at the slow line clock
        rhalf = 200;
        settle(4);
        for (int i = 0; i < 30; i++) write_byte(8'(8'hC0 + i), i == 29);
        settle(4);
        chk("R9", "start_ok slow", int'(rd_start_ok), 1);
        for (int i = 0; i < 5; i++) read_one("R9");
        pulse_rewind();
        pulse_acq();
        for (int i = 0; i < 30; i++) read_one("R9");
        settle(4);
        chk("R9", "valid after slow frame", int'(rd_valid), 0);

        done = 1;
        summary();
        $finish;
    end
endmodule